// File: doc/BRIEF.md
# Barrel Shifter with Shift Carry

This block is the second-operand shifter in front of an integer ALU. It takes a 32-bit operand, a shift kind, a shift count and the current carry flag. In the same cycle it returns the shifted operand and a shift carry. The shift carry is the last bit that moved out of the operand. For a zero count, the incoming carry passes through instead.

There are five shift kinds. Left and right logical shifts fill with zeros. The arithmetic right shift fills with copies of the sign bit. The rotate right takes its count modulo the width. The extended rotate treats the carry flag as a 33rd bit sitting above bit 31 and moves everything one place. The block has no registers and no states. Each operation is a fixed path of mux stages, one stage for each bit of the count. The carry result goes only to the ALU. Keeping the flags is the job of the logic around the block.

Top module: `shf_barrel`

## Requirements
- R1: For kinds LSL, LSR, ASR and ROR with a count of 0, the result equals the operand and the shift carry equals the incoming carry.
- R2: LSL (kind code 0) with a count n from 1 to 31 gives the operand shifted left by n with zeros in the low n bits, and shift carry = operand bit 32-n.
- R3: LSR (kind code 1) with a count n from 1 to 31 gives the operand shifted right by n with zeros in the high n bits, and shift carry = operand bit n-1.
- R4: ASR (kind code 2) with a count n from 1 to 31 gives the operand shifted right by n with the high n bits equal to operand bit 31, and shift carry = operand bit n-1.
- R5: ROR (kind code 3) with a count n from 1 to 31 gives the operand rotated right by n, and shift carry = result bit 31 (= operand bit n-1).
- R6: A count of 32 with LSL or LSR gives a zero result. The shift carry is operand bit 0 for LSL and operand bit 31 for LSR.
- R7: ASR with a count of 32 gives every result bit equal to operand bit 31, and shift carry = operand bit 31.
- R8: ROR uses the count modulo 32. A count of 32 returns the operand unchanged with shift carry = operand bit 31. Counts 33 to 63 rotate by count-32.
- R9: RRX (kind code 4) gives {incoming carry, operand[31:1]} with shift carry = operand bit 0, whatever the count.
- R10: Kind codes 5 to 7 pass the operand through unchanged, with shift carry = incoming carry.
- R11: Both outputs are purely combinational and settle in the same cycle as the inputs, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value_i | input | 32 | Operand to shift |
| kind_i | input | 3 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX |
| amount_i | input | 6 | Shift count, 0 to 32 (ROR accepts up to 63) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shift carry for the ALU |

## Verification
Every result is due in the same cycle as its stimulus, because no register sits between the ports. The bench applies each input set on a falling clock edge. It reads both outputs 5 ns later, well away from any rising edge. The expected value and carry come from a behavioural reference written with the language's own shift operators. That reference shares nothing with the staged muxes. Directed tasks cover each kind at count 0, mid-range counts, count 32, the modulo counts for ROR, and the unused kind codes.

// File: rtl/shf_pkg.sv
package shf_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        SHK_LSL = 3'd0,
        SHK_LSR = 3'd1,
        SHK_ASR = 3'd2,
        SHK_ROR = 3'd3,
        SHK_RRX = 3'd4
    } shf_kind_e;
endpackage

// File: rtl/shf_left_unit.sv
module shf_left_unit #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic [W-1:0]  val_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  res_o,
    output logic          carry_o
);
    // bit W is a guard that catches the last bit shifted out
    logic [W:0] stg [0:AW];

    assign stg[0] = {1'b0, val_i};

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+1] = amt_i[k] ? {stg[k][W-SH:0], {SH{1'b0}}} : stg[k];
    end

    assign res_o   = stg[AW][W-1:0];
    assign carry_o = stg[AW][W];

    always_comb begin
        if (amt_i == '0) begin
            a_r1_left_idle: assert (res_o == val_i)
                else $error("left unit altered operand at zero count");
        end
        if (amt_i == AW'(W)) begin
            a_r6_left_full: assert (res_o == '0 && carry_o == val_i[0])
                else $error("left unit full-width shift wrong");
        end
    end
endmodule

// File: rtl/shf_right_unit.sv
module shf_right_unit #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic [W-1:0]  val_i,
    input  logic [AW-1:0] amt_i,
    input  logic          arith_i,
    output logic [W-1:0]  res_o,
    output logic          carry_o
);
    logic       fill;
    // bit 0 is a guard that catches the last bit shifted out
    logic [W:0] stg [0:AW];

    assign fill   = arith_i & val_i[W-1];
    assign stg[0] = {val_i, 1'b0};

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+1] = amt_i[k] ? {{SH{fill}}, stg[k][W:SH]} : stg[k];
    end

    assign res_o   = stg[AW][W:1];
    assign carry_o = stg[AW][0];

    always_comb begin
        if (arith_i && val_i[W-1] && amt_i != '0) begin
            a_r4_sign_fill: assert (res_o[W-1])
                else $error("arithmetic shift lost sign");
        end
        if (!arith_i && amt_i != '0 && amt_i <= AW'(W)) begin
            a_r3_zero_fill: assert (!res_o[W-1])
                else $error("logical right shift filled with one");
        end
    end
endmodule

// File: rtl/shf_rot_unit.sv
module shf_rot_unit #(
    parameter int W  = 32,
    parameter int RW = 5
) (
    input  logic [W-1:0]  val_i,
    input  logic [RW-1:0] amt_i,
    input  logic          rrx_i,
    input  logic          cin_i,
    output logic [W-1:0]  res_o,
    output logic          carry_o
);
    logic [W-1:0] stg [0:RW];

    assign stg[0] = val_i;

    for (genvar k = 0; k < RW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+1] = amt_i[k] ? {stg[k][SH-1:0], stg[k][W-1:SH]} : stg[k];
    end

    always_comb begin
        if (rrx_i) begin
            res_o   = {cin_i, val_i[W-1:1]};
            carry_o = val_i[0];
        end else begin
            res_o   = stg[RW];
            carry_o = stg[RW][W-1];
        end
    end

    always_comb begin
        if (!rrx_i) begin
            a_r5_bits_kept: assert ($countones(res_o) == $countones(val_i))
                else $error("rotate changed population count");
        end
    end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
    import shf_pkg::*;
#(
    parameter  int DATA_W = shf_pkg::DATA_W,
    localparam int AMT_W  = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [2:0]        kind_i,
    input  logic [AMT_W-1:0]  amount_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    localparam int ROT_W = AMT_W - 1;

    shf_kind_e         kind;
    logic [DATA_W-1:0] lft_res, rgt_res, rot_res;
    logic              lft_c, rgt_c, rot_c;
    logic              is_zero;

    assign kind    = shf_kind_e'(kind_i);
    assign is_zero = (amount_i == '0);

    shf_left_unit #(.W(DATA_W), .AW(AMT_W)) u_left (
        .val_i   (value_i),
        .amt_i   (amount_i),
        .res_o   (lft_res),
        .carry_o (lft_c)
    );

    shf_right_unit #(.W(DATA_W), .AW(AMT_W)) u_right (
        .val_i   (value_i),
        .amt_i   (amount_i),
        .arith_i (kind == SHK_ASR),
        .res_o   (rgt_res),
        .carry_o (rgt_c)
    );

    shf_rot_unit #(.W(DATA_W), .RW(ROT_W)) u_rot (
        .val_i   (value_i),
        .amt_i   (amount_i[ROT_W-1:0]),
        .rrx_i   (kind == SHK_RRX),
        .cin_i   (carry_i),
        .res_o   (rot_res),
        .carry_o (rot_c)
    );

    always_comb begin
        result_o = value_i;
        carry_o  = carry_i;
        unique case (kind)
            SHK_LSL: if (!is_zero) begin result_o = lft_res; carry_o = lft_c; end
            SHK_LSR,
            SHK_ASR: if (!is_zero) begin result_o = rgt_res; carry_o = rgt_c; end
            SHK_ROR: if (!is_zero) begin result_o = rot_res; carry_o = rot_c; end
            SHK_RRX: begin result_o = rot_res; carry_o = rot_c; end
            default: ;
        endcase
    end

    always_comb begin
        if (kind_i == 3'd4) begin
            a_r9_rrx_carry: assert (carry_o == value_i[0] &&
                                    result_o[DATA_W-1] == carry_i)
                else $error("extended rotate carry path wrong");
        end
        if (kind_i > 3'd4 || (kind_i < 3'd4 && is_zero)) begin
            a_r1_passthru: assert (result_o == value_i && carry_o == carry_i)
                else $error("pass-through case altered outputs");
        end
        if (kind_i == 3'd1 && amount_i == AMT_W'(DATA_W)) begin
            a_r6_lsr_full: assert (result_o == '0 && carry_o == value_i[DATA_W-1])
                else $error("full logical right shift wrong");
        end
    end
endmodule

// File: tb/test_shf_barrel.sv
module test_shf_barrel;
    logic        clk = 1'b0;
    logic [31:0] value;
    logic [2:0]  kind;
    logic [5:0]  amount;
    logic        cin;
    logic [31:0] result;
    logic        cout;
    int          n_checks = 0;
    int          n_fail   = 0;

    always #10 clk = ~clk;

    shf_barrel i_shf_barrel (
        .value_i  (value),
        .kind_i   (kind),
        .amount_i (amount),
        .carry_i  (cin),
        .result_o (result),
        .carry_o  (cout)
    );

    // behavioural reference built on language shift operators
    function automatic logic [32:0] ref_model(logic [31:0] v, logic [2:0] k,
                                              logic [5:0] n, logic c);
        logic [32:0] t;
        logic [31:0] r;
        int          m;
        case (k)
            3'd0: begin
                if (n == 0) return {c, v};
                t = {1'b0, v} << n;
                return {t[32], t[31:0]};
            end
            3'd1: begin
                if (n == 0) return {c, v};
                t = {v, 1'b0} >> n;
                return {t[0], t[32:1]};
            end
            3'd2: begin
                if (n == 0) return {c, v};
                t = 33'($signed({v, 1'b0}) >>> n);
                return {t[0], t[32:1]};
            end
            3'd3: begin
                if (n == 0) return {c, v};
                m = int'(n) % 32;
                r = (m == 0) ? v : ((v >> m) | (v << (32 - m)));
                return {r[31], r};
            end
            3'd4: return {v[0], c, v[31:1]};
            default: return {c, v};
        endcase
    endfunction

    task automatic apply_check(input string tag, input logic [31:0] v,
                               input logic [2:0] k, input logic [5:0] n,
                               input logic c);
        logic [32:0] exp;
        @(negedge clk);
        value = v; kind = k; amount = n; cin = c;
        #5;
        exp = ref_model(v, k, n, c);
        n_checks++;
        if ({cout, result} !== exp) begin
            n_fail++;
            $display("FAIL %s kind=%0d n=%0d v=%h: got c=%b r=%h exp c=%b r=%h",
                     tag, k, n, v, cout, result, exp[32], exp[31:0]);
        end
    endtask

    task automatic t_r1_zero_count();
        for (int k = 0; k < 4; k++) begin
            apply_check("R1", 32'hA5C3_0F81, 3'(k), 6'd0, 1'b1);
            apply_check("R1", 32'h7F00_00FE, 3'(k), 6'd0, 1'b0);
        end
    endtask

    task automatic t_r2_lsl();
        apply_check("R2", 32'h8000_0001, 3'd0, 6'd1, 1'b0);
        apply_check("R2", 32'h1234_5678, 3'd0, 6'd4, 1'b0);
        apply_check("R2", 32'h0000_0003, 3'd0, 6'd31, 1'b1);
        apply_check("R2", 32'hF0F0_F0F0, 3'd0, 6'd17, 1'b0);
    endtask

    task automatic t_r3_lsr();
        apply_check("R3", 32'h8000_0001, 3'd1, 6'd1, 1'b0);
        apply_check("R3", 32'hFFFF_FFFF, 3'd1, 6'd31, 1'b0);
        apply_check("R3", 32'h0001_0000, 3'd1, 6'd17, 1'b1);
    endtask

    task automatic t_r4_asr();
        apply_check("R4", 32'h8000_0000, 3'd2, 6'd1, 1'b0);
        apply_check("R4", 32'h9234_5679, 3'd2, 6'd8, 1'b0);
        apply_check("R4", 32'h7FFF_FFFF, 3'd2, 6'd31, 1'b0);
        apply_check("R4", 32'hC000_0040, 3'd2, 6'd7, 1'b1);
    endtask

    task automatic t_r5_ror();
        apply_check("R5", 32'h0000_0001, 3'd3, 6'd1, 1'b0);
        apply_check("R5", 32'h1234_5678, 3'd3, 6'd12, 1'b1);
        apply_check("R5", 32'h8000_0002, 3'd3, 6'd31, 1'b0);
    endtask

    task automatic t_r6_full_logical();
        apply_check("R6", 32'h0000_0001, 3'd0, 6'd32, 1'b0);
        apply_check("R6", 32'hFFFF_FFFE, 3'd0, 6'd32, 1'b1);
        apply_check("R6", 32'h8000_0000, 3'd1, 6'd32, 1'b0);
        apply_check("R6", 32'h7FFF_FFFF, 3'd1, 6'd32, 1'b1);
    endtask

    task automatic t_r7_full_arith();
        apply_check("R7", 32'h8000_1234, 3'd2, 6'd32, 1'b0);
        apply_check("R7", 32'h7FFF_1234, 3'd2, 6'd32, 1'b1);
    endtask

    task automatic t_r8_ror_modulo();
        apply_check("R8", 32'h8765_4321, 3'd3, 6'd32, 1'b0);
        apply_check("R8", 32'h0765_4321, 3'd3, 6'd32, 1'b1);
        apply_check("R8", 32'h1234_5678, 3'd3, 6'd36, 1'b0);
        apply_check("R8", 32'hDEAD_BEEF, 3'd3, 6'd63, 1'b0);
    endtask

    task automatic t_r9_rrx();
        apply_check("R9", 32'h0000_0001, 3'd4, 6'd0, 1'b0);
        apply_check("R9", 32'h8000_0000, 3'd4, 6'd5, 1'b1);
        apply_check("R9", 32'h1234_5679, 3'd4, 6'd32, 1'b1);
    endtask

    task automatic t_r10_spare_codes();
        for (int k = 5; k < 8; k++)
            apply_check("R10", 32'hCAFE_F00D, 3'(k), 6'd9, 1'b1);
    endtask

    task automatic t_r11_sweep();
        logic [31:0] v = 32'h9E37_79B9;
        for (int k = 0; k < 4; k++)
            for (int n = 0; n <= 32; n++) begin
                apply_check("R11", v, 3'(k), 6'(n), n[0]);
                v = {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
            end
    endtask

    initial begin
        value = '0; kind = '0; amount = '0; cin = 1'b0;
        t_r1_zero_count();
        t_r2_lsl();
        t_r3_lsr();
        t_r4_asr();
        t_r5_ror();
        t_r6_full_logical();
        t_r7_full_arith();
        t_r8_ror_modulo();
        t_r9_rrx();
        t_r10_spare_codes();
        t_r11_sweep();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule